// File: doc/BRIEF.md
# USB Host Port Connection Controller

This block follows the life of one downstream USB host port, from attach through bus reset to normal operation. It watches session-level flags from the analog front end (VBUS valid, session end), two line-state inputs that show which data line carries a device pull-up, and a slow timer tick used for debouncing. Software controls the port through a power bit and a reset bit. A mode input tells the block whether the OTG session protocols are active. When they are active, a device attach is held off until VBUS is valid.

Every event of interest is kept in a sticky flag that software clears by writing a one. The events are attach, removal, debounce finished, session end, and port enabled. A masked OR of the flags drives a single interrupt line. Once software has waited for the debounce flag and then held the reset bit for the time the bus requires, the port drives single-ended zero. When the reset bit drops, the port enables itself, reports the device speed, and from then on emits one frame marker per frame strobe. The marker is a start-of-frame for a full-speed device and a keep-alive for a low-speed device.

Top module: `usb_host_port_ctrl`

## Requirements
- R1: After reset, `flags`, `irq`, `port_connected`, `port_enabled`, `port_speed`, `bus_se0`, `mark_sof` and `mark_keepalive` are all zero.
- R2: With `otg_proto_en`=1, a pull-up with `pwr_on`=1 does not set the attach flag (`flags[0]`) while `vbus_valid`=0. The flag sets on the clock edge at which `vbus_valid` is first seen high.
- R3: With `otg_proto_en`=0, the attach flag `flags[0]` sets on the first clock edge that sees a pull-up on either line while `pwr_on`=1, whatever the value of `vbus_valid`.
- R4: When both pull-ups vanish, or `pwr_on` drops, on an attached port, the removal flag `flags[1]` sets on that edge. On the same edge `port_connected` and `port_enabled` clear and `port_speed` returns to 2'b00.
- R5: The debounce flag `flags[2]` sets on the edge that carries the DBNC_TICKS-th `dbnc_tick` after attach. Any change of the line pair before that point restarts the count from zero.
- R6: Setting `prst` before the debounce has finished has no effect: `bus_se0` stays 0 and the port stays disabled.
- R7: Setting `prst` on a debounced, attached port makes `bus_se0` go high from the next edge. It stays high until the edge that sees `prst` cleared.
- R8: On the edge that sees `prst` cleared after a bus reset, `port_enabled` goes to 1 and the enable-change flag `flags[4]` sets. `port_speed` then reads 2'b01 if the debounced line pair had the D+ pull-up, or 2'b10 if it had only the D− pull-up.
- R9: A `frame_tick` on an enabled port gives a one-cycle pulse on the next cycle: on `mark_sof` for full speed or on `mark_keepalive` for low speed. A disabled port gives no pulse.
- R10: A rising edge of `sess_end` while `pwr_on`=1 sets the session-end flag `flags[3]`. A rising edge while `pwr_on`=0 does not set it.
- R11: A one in `flag_clr[i]` clears `flags[i]` on the next edge. If an event for the same flag occurs on that edge, the event wins and the flag stays set.
- R12: `irq` is high exactly when some `flags[i]` and `irq_mask[i]` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| otg_proto_en | input | 1 | OTG session protocols enabled; attach then needs VBUS valid |
| vbus_valid | input | 1 | VBUS at valid level |
| sess_end | input | 1 | Session end detected |
| dp_pullup | input | 1 | Pull-up seen on D+ |
| dm_pullup | input | 1 | Pull-up seen on D− |
| dbnc_tick | input | 1 | Debounce timer tick, one cycle wide |
| frame_tick | input | 1 | Frame strobe, one cycle wide |
| pwr_on | input | 1 | Port power control bit |
| prst | input | 1 | Port reset control bit, timed by software |
| flag_clr | input | 5 | Write-one-to-clear strobes, one per flag |
| irq_mask | input | 5 | Interrupt enable per flag |
| flags | output | 5 | Sticky flags: 0 attach, 1 removal, 2 debounce done, 3 session end, 4 enable change |
| irq | output | 1 | Masked OR of the flags |
| port_connected | output | 1 | A device is attached |
| port_enabled | output | 1 | Port enabled after bus reset |
| port_speed | output | 2 | 00 none, 01 full speed, 10 low speed |
| bus_se0 | output | 1 | Port drives single-ended zero (bus reset) |
| mark_sof | output | 1 | Start-of-frame marker pulse |
| mark_keepalive | output | 1 | Keep-alive marker pulse |

## Verification
Every flag, together with `port_connected`, `port_enabled`, `port_speed` and `bus_se0`, changes on the first clock edge that sees the causing input. Frame markers appear one cycle after the edge that sees `frame_tick`, and `irq` follows the flags and mask with no extra delay. The bench drives inputs on the falling edge, advances through exactly one rising edge per stimulus, and samples on the next falling edge, so each check reads the value due right after the edge that acted. Debounce checks count ticks one per edge and look at the flag after the tick just before the final one and again after the final one.

// File: rtl/usbhp_pkg.sv
package usbhp_pkg;

    localparam int NUM_FLAGS = 5;
    localparam int FLG_CONN  = 0;
    localparam int FLG_DISC  = 1;
    localparam int FLG_DBNC  = 2;
    localparam int FLG_SEND  = 3;
    localparam int FLG_PENC  = 4;

    typedef enum logic [1:0] {
        SPD_NONE = 2'b00,
        SPD_FULL = 2'b01,
        SPD_LOW  = 2'b10
    } speed_e;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'b00,
        PS_RESET   = 2'b01,
        PS_ENABLED = 2'b10
    } port_state_e;

    typedef struct packed {
        logic dm_up;
        logic dp_up;
    } line_t;

    // Packed so that conn sits at bit 0 and penc at bit 4.
    typedef struct packed {
        logic penc;
        logic send;
        logic dbnc;
        logic disc;
        logic conn;
    } flag_evt_t;

    function automatic logic line_present(input line_t l);
        return l.dp_up | l.dm_up;
    endfunction

    function automatic speed_e line_speed(input line_t l);
        if (l.dp_up)      return SPD_FULL;
        else if (l.dm_up) return SPD_LOW;
        else              return SPD_NONE;
    endfunction

endpackage

// File: rtl/usbhp_attach.sv
module usbhp_attach
    import usbhp_pkg::*;
#(
    parameter int DBNC_TICKS = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   otg_proto_en,
    input  logic   vbus_valid,
    input  logic   pwr_on,
    input  line_t  line,
    input  logic   dbnc_tick,
    output logic   connected,
    output logic   debounced,
    output speed_e det_speed,
    output logic   conn_evt,
    output logic   disc_evt,
    output logic   dbnc_evt
);

    localparam int            CW   = $clog2(DBNC_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DBNC_TICKS - 1);

    logic [CW-1:0] cnt_q;
    line_t         ref_q;
    logic          gate_ok;
    logic          line_chg;

    always_comb begin
        gate_ok  = !otg_proto_en || vbus_valid;
        conn_evt = !connected && pwr_on && gate_ok && line_present(line);
        disc_evt = connected && (!pwr_on || !line_present(line));
        line_chg = connected && !debounced && !disc_evt && (line != ref_q);
        dbnc_evt = connected && !debounced && !disc_evt && !line_chg &&
                   dbnc_tick && (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            connected <= 1'b0;
            debounced <= 1'b0;
            det_speed <= SPD_NONE;
            cnt_q     <= '0;
            ref_q     <= '0;
        end else if (conn_evt) begin
            connected <= 1'b1;
            debounced <= 1'b0;
            cnt_q     <= '0;
            ref_q     <= line;
        end else if (disc_evt) begin
            connected <= 1'b0;
            debounced <= 1'b0;
            det_speed <= SPD_NONE;
            cnt_q     <= '0;
        end else if (connected && !debounced) begin
            if (line_chg) begin
                ref_q <= line;
                cnt_q <= '0;
            end else if (dbnc_evt) begin
                debounced <= 1'b1;
                det_speed <= line_speed(ref_q);
            end else if (dbnc_tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_ATTACH_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(connected) |-> (!$past(otg_proto_en) || $past(vbus_valid))); // R2
    AST_DBNC_NEEDS_LINK: assert property (@(posedge clk) disable iff (rst)
        debounced |-> connected); // R5
    AST_DBNC_HAS_SPEED: assert property (@(posedge clk) disable iff (rst)
        debounced |-> (det_speed != SPD_NONE)); // R8

endmodule

// File: rtl/usbhp_port_fsm.sv
module usbhp_port_fsm
    import usbhp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   connected,
    input  logic   disc_evt,
    input  logic   debounced,
    input  speed_e det_speed,
    input  logic   prst,
    input  logic   frame_tick,
    output logic   port_enabled,
    output speed_e port_speed,
    output logic   bus_se0,
    output logic   mark_sof,
    output logic   mark_keepalive,
    output logic   pe_evt
);

    port_state_e state_q, state_d;
    speed_e      speed_d;

    always_comb begin
        state_d = state_q;
        speed_d = port_speed;
        pe_evt  = 1'b0;
        if (!connected || disc_evt) begin
            state_d = PS_IDLE;
            speed_d = SPD_NONE;
        end else begin
            case (state_q)
                PS_IDLE: begin
                    if (prst && debounced) state_d = PS_RESET;
                end
                PS_RESET: begin
                    if (!prst) begin
                        state_d = PS_ENABLED;
                        speed_d = det_speed;
                        pe_evt  = 1'b1;
                    end
                end
                PS_ENABLED: begin
                    if (prst) begin
                        state_d = PS_RESET;
                        speed_d = SPD_NONE;
                    end
                end
                default: state_d = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= PS_IDLE;
            port_speed     <= SPD_NONE;
            mark_sof       <= 1'b0;
            mark_keepalive <= 1'b0;
        end else begin
            state_q        <= state_d;
            port_speed     <= speed_d;
            mark_sof       <= frame_tick && (state_q == PS_ENABLED) &&
                              (port_speed == SPD_FULL);
            mark_keepalive <= frame_tick && (state_q == PS_ENABLED) &&
                              (port_speed == SPD_LOW);
        end
    end

    assign port_enabled = (state_q == PS_ENABLED);
    assign bus_se0      = (state_q == PS_RESET);

    AST_SE0_AFTER_DBNC: assert property (@(posedge clk) disable iff (rst)
        bus_se0 |-> debounced); // R6
    AST_ENABLE_SPEED: assert property (@(posedge clk) disable iff (rst)
        port_enabled |-> (port_speed != SPD_NONE)); // R8
    AST_MARK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mark_sof && mark_keepalive)); // R9
    AST_MARK_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (mark_sof || mark_keepalive) |-> $past(port_enabled)); // R9

endmodule

// File: rtl/usbhp_flags.sv
module usbhp_flags
    import usbhp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  flag_evt_t            evt,
    input  logic                 sess_end,
    input  logic                 pwr_on,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    input  logic [NUM_FLAGS-1:0] irq_mask,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);

    logic                 sess_q;
    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] masked;
    flag_evt_t            evt_all;

    always_comb begin
        evt_all      = evt;
        evt_all.send = sess_end && !sess_q && pwr_on;
        set_v        = evt_all;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sess_q <= 1'b1;
            flags  <= '0;
        end else begin
            sess_q <= sess_end;
            for (int b = 0; b < NUM_FLAGS; b++) begin
                if (set_v[b])         flags[b] <= 1'b1;
                else if (flag_clr[b]) flags[b] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_mask
        assign masked[g] = flags[g] & irq_mask[g];
    end

    assign irq = |masked;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_clr == '0) |=> ((flags & $past(flags)) == $past(flags))); // R11
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == '0) |-> !irq); // R12

endmodule

// File: rtl/usb_host_port_ctrl.sv
module usb_host_port_ctrl
    import usbhp_pkg::*;
#(
    parameter int DBNC_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       otg_proto_en,
    input  logic       vbus_valid,
    input  logic       sess_end,
    input  logic       dp_pullup,
    input  logic       dm_pullup,
    input  logic       dbnc_tick,
    input  logic       frame_tick,
    input  logic       pwr_on,
    input  logic       prst,
    input  logic [4:0] flag_clr,
    input  logic [4:0] irq_mask,
    output logic [4:0] flags,
    output logic       irq,
    output logic       port_connected,
    output logic       port_enabled,
    output logic [1:0] port_speed,
    output logic       bus_se0,
    output logic       mark_sof,
    output logic       mark_keepalive
);

    line_t     line;
    logic      debounced;
    speed_e    det_speed;
    speed_e    spd;
    logic      conn_evt, disc_evt, dbnc_evt, pe_evt;
    flag_evt_t evt;

    always_comb begin
        line.dp_up = dp_pullup;
        line.dm_up = dm_pullup;
        evt        = '0;
        evt.conn   = conn_evt;
        evt.disc   = disc_evt;
        evt.dbnc   = dbnc_evt;
        evt.penc   = pe_evt;
    end

    usbhp_attach #(.DBNC_TICKS(DBNC_TICKS)) u_attach (
        .clk          (clk),
        .rst          (rst),
        .otg_proto_en (otg_proto_en),
        .vbus_valid   (vbus_valid),
        .pwr_on       (pwr_on),
        .line         (line),
        .dbnc_tick    (dbnc_tick),
        .connected    (port_connected),
        .debounced    (debounced),
        .det_speed    (det_speed),
        .conn_evt     (conn_evt),
        .disc_evt     (disc_evt),
        .dbnc_evt     (dbnc_evt)
    );

    usbhp_port_fsm u_port (
        .clk            (clk),
        .rst            (rst),
        .connected      (port_connected),
        .disc_evt       (disc_evt),
        .debounced      (debounced),
        .det_speed      (det_speed),
        .prst           (prst),
        .frame_tick     (frame_tick),
        .port_enabled   (port_enabled),
        .port_speed     (spd),
        .bus_se0        (bus_se0),
        .mark_sof       (mark_sof),
        .mark_keepalive (mark_keepalive),
        .pe_evt         (pe_evt)
    );

    usbhp_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .sess_end (sess_end),
        .pwr_on   (pwr_on),
        .flag_clr (flag_clr),
        .irq_mask (irq_mask),
        .flags    (flags),
        .irq      (irq)
    );

    assign port_speed = spd;

endmodule

// File: tb/tb_usb_host_port_ctrl.sv
module tb_usb_host_port_ctrl;

    localparam int DBNC = 4;
    // Vector: [7] otg_en [6] vbus [5] dp [4] dm [3] expect attach [1:0] expect speed
    localparam logic [7:0] VEC [6] = '{
        8'b1010_0000,
        8'b1110_1001,
        8'b1101_1010,
        8'b0010_1001,
        8'b0001_1010,
        8'b0100_0000
    };

    logic       clk = 1'b0;
    logic       rst, otg_proto_en, vbus_valid, sess_end, dp_pullup, dm_pullup;
    logic       dbnc_tick, frame_tick, pwr_on, prst;
    logic [4:0] flag_clr, irq_mask, flags;
    logic       irq, port_connected, port_enabled, bus_se0, mark_sof, mark_keepalive;
    logic [1:0] port_speed;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    usb_host_port_ctrl #(.DBNC_TICKS(DBNC)) dut (.*);

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            dbnc_tick = 1'b1;
            step();
            dbnc_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; otg_proto_en = 1'b0; vbus_valid = 1'b0; sess_end = 1'b0;
        dp_pullup = 1'b0; dm_pullup = 1'b0; dbnc_tick = 1'b0; frame_tick = 1'b0;
        pwr_on = 1'b0; prst = 1'b0; flag_clr = '0; irq_mask = '0;
        step(2);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        step();
        // R1 reset state
        chk("R1 flags", flags, 0);
        chk("R1 irq", irq, 0);
        chk("R1 state", {port_connected, port_enabled, port_speed, bus_se0,
                         mark_sof, mark_keepalive}, 0);

        // Table walk: attach gating, debounce, reset, speed, markers
        for (int i = 0; i < 6; i++) begin
            do_reset();
            pwr_on = 1'b1;
            otg_proto_en = VEC[i][7]; vbus_valid = VEC[i][6];
            dp_pullup = VEC[i][5];    dm_pullup = VEC[i][4];
            step();
            chk("R2/R3 attach flag", flags[0], VEC[i][3]);
            if (VEC[i][3]) begin
                tick(DBNC - 1);
                chk("R5 debounce early", flags[2], 0);
                tick(1);
                chk("R5 debounce done", flags[2], 1);
                prst = 1'b1;
                step();
                chk("R7 se0 on", bus_se0, 1);
                step(3);
                chk("R7 se0 held", bus_se0, 1);
                prst = 1'b0;
                step();
                chk("R7 se0 off", bus_se0, 0);
                chk("R8 enabled", port_enabled, 1);
                chk("R8 enable flag", flags[4], 1);
                chk("R8 speed", port_speed, VEC[i][1:0]);
                frame_tick = 1'b1;
                step();
                frame_tick = 1'b0;
                chk("R9 marker", {mark_sof, mark_keepalive},
                    (VEC[i][1:0] == 2'b01) ? 2'b10 : 2'b01);
                step();
                chk("R9 marker one cycle", {mark_sof, mark_keepalive}, 0);
            end else begin
                chk("R2/R3 no attach", port_connected, 0);
            end
        end

        // R2: attach held until VBUS valid
        do_reset();
        pwr_on = 1'b1; otg_proto_en = 1'b1; dp_pullup = 1'b1;
        step(3);
        chk("R2 held off", flags[0], 0);
        vbus_valid = 1'b1;
        step();
        chk("R2 released", flags[0], 1);

        // R5 restart on line change, R6 early reset ignored
        do_reset();
        pwr_on = 1'b1; dp_pullup = 1'b1;
        step();
        tick(2);
        dp_pullup = 1'b0; dm_pullup = 1'b1;
        step();
        tick(DBNC - 1);
        chk("R5 restart", flags[2], 0);
        prst = 1'b1;
        step();
        chk("R6 se0 ignored", bus_se0, 0);
        chk("R6 still disabled", port_enabled, 0);
        prst = 1'b0;
        tick(1);
        chk("R5 done after restart", flags[2], 1);
        prst = 1'b1;
        step();
        prst = 1'b0;
        step();
        chk("R8 low speed after restart", port_speed, 2'b10);

        // R4 removal
        dm_pullup = 1'b0;
        step();
        chk("R4 removal flag", flags[1], 1);
        chk("R4 link down", {port_connected, port_enabled, port_speed}, 0);
        frame_tick = 1'b1;
        step();
        frame_tick = 1'b0;
        chk("R9 no marker disabled", {mark_sof, mark_keepalive}, 0);

        // R11 clear and set-wins
        flag_clr = 5'b00010;
        step();
        flag_clr = '0;
        chk("R11 cleared", flags[1], 0);
        chk("R11 others kept", flags[0], 1);
        flag_clr = 5'b00001;
        step();
        chk("R11 attach cleared", flags[0], 0);
        dp_pullup = 1'b1;
        step();
        flag_clr = '0;
        chk("R11 set wins", flags[0], 1);

        // R10 session end, R12 irq masking
        flag_clr = 5'b11111;
        step();
        flag_clr = '0;
        irq_mask = 5'b01000;
        sess_end = 1'b1;
        step();
        chk("R10 session end", flags[3], 1);
        chk("R12 irq on", irq, 1);
        irq_mask = 5'b00001;
        step();
        chk("R12 irq masked", irq, 0);
        sess_end = 1'b0; pwr_on = 1'b0;
        step();
        flag_clr = 5'b11111;
        step();
        flag_clr = '0;
        sess_end = 1'b1;
        step();
        chk("R10 no power no flag", flags[3], 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule